// File: doc/BRIEF.md
# Hypervisor interrupt pending aggregator

This block builds the hypervisor-level view of pending interrupts for a hart that supports guest virtualization, and picks the single interrupt that hypervisor-supervisor mode should take next. It holds the three-bit software injection register for virtual supervisor interrupts. It folds guest external interrupt lines from an interrupt controller into a single wake-up flag for the hypervisor, and routes one selected guest line through to the guest as its external interrupt. It also merges a platform external signal and a virtual timer compare result into the matching pending bits.

The supervisor pending and enable vectors and the hypervisor enable vector come in from the surrounding CSR file. The block presents the hypervisor pending read value, the reduced guest-external flag and the winning interrupt code, each registered. The hypervisor bit positions (12, 10, 6, 2) never overlap the supervisor positions (9, 5, 1, 13). Host interrupts always rank ahead of guest ones.

Top module: `hv_irq_aggregator`

## Requirements
- R1: A synchronous active-high reset clears the injection register and drives `inj_rd_o`, `hyp_pend_o`, `sgei_flag_o`, `irq_valid_o` and `irq_code_o` to zero.
- R2: A write on the injection port stores only data bits 10, 6 and 2. `inj_rd_o` reads every other bit as zero, and the new value shows on `inj_rd_o` after the write edge.
- R3: The pending-alias write port changes only injection bit 2. If both write ports fire in the same cycle, bit 2 takes the alias data and bits 10 and 6 take the injection data.
- R4: `sgei_flag_o` and `hyp_pend_o[12]` are 1 exactly when `gst_pend_i & gst_en_i` is nonzero over bits 1 to GEILEN. Bit 0 and bits above GEILEN never count, and with GEILEN=0 the flag stays 0.
- R5: `hyp_pend_o[10]` is the OR of injection bit 10, `plat_vsext_i`, and `gst_pend_i[gst_sel_i]`. The last term counts only when the selector is between 1 and GEILEN, so it is ignored entirely when GEILEN=0.
- R6: `hyp_pend_o[6]` is injection bit 6 OR `vtimer_hit_i`.
- R7: `hyp_pend_o[2]` equals injection bit 2.
- R8: `hyp_pend_o` is zero outside bits 12, 10, 6 and 2. Supervisor inputs count only at bits 9, 1, 5 and 13, and hypervisor enables count only at bits 12, 10, 6 and 2.
- R9: The chosen code is the first interrupt that is both pending and enabled, in the order 9, 1, 5, 12, 10, 2, 6, 13.
- R10: When no interrupt is both pending and enabled, `irq_valid_o` and `irq_code_o` are both 0.
- R11: `hyp_pend_o`, `sgei_flag_o`, `irq_valid_o` and `irq_code_o` follow their inputs with one register stage. An injection write therefore reaches `hyp_pend_o` one edge after it reaches `inj_rd_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inj_we_i | input | 1 | Injection register write strobe |
| inj_wdata_i | input | XLEN | Injection register write data |
| alias_we_i | input | 1 | Hypervisor pending write strobe (alias of injection bit 2) |
| alias_wdata_i | input | XLEN | Hypervisor pending write data |
| gst_pend_i | input | XLEN | Guest external interrupt pending lines |
| gst_en_i | input | XLEN | Guest external interrupt enables |
| gst_sel_i | input | $clog2(XLEN) | Index of the guest line passed through to the guest |
| plat_vsext_i | input | 1 | Platform virtual supervisor external interrupt |
| vtimer_hit_i | input | 1 | Virtual timer comparator result |
| sup_pend_i | input | XLEN | Supervisor pending vector |
| sup_en_i | input | XLEN | Supervisor enable vector |
| hyp_en_i | input | XLEN | Hypervisor enable vector |
| inj_rd_o | output | XLEN | Injection register read value |
| hyp_pend_o | output | XLEN | Hypervisor pending read value |
| sgei_flag_o | output | 1 | Reduced guest external flag |
| irq_valid_o | output | 1 | An interrupt is pending and enabled |
| irq_code_o | output | 6 | Code of the selected interrupt |

## Verification
Both write ports can hit the injection register in the same cycle, and the bench pulses them together with conflicting data. It then judges each stored bit separately: bit 2 must follow the alias data, while bits 10 and 6 must follow the injection data. The virtual external bit can also be raised by injection, pass-through and the platform line at once, and it competes in the same cycle with the guest-external flag driven by the same pending lines. Table vectors set these sources together and compare the chosen code against the fixed priority order. A second instance built with GEILEN=0 receives the same stimulus and must ignore the selector.

// File: rtl/hv_irq_pkg.sv
package hv_irq_pkg;
  localparam int unsigned CODE_W = 6;
  localparam int unsigned N_PRIO = 8;

  localparam int unsigned B_SSI  = 1;
  localparam int unsigned B_VSSI = 2;
  localparam int unsigned B_STI  = 5;
  localparam int unsigned B_VSTI = 6;
  localparam int unsigned B_SEI  = 9;
  localparam int unsigned B_VSEI = 10;
  localparam int unsigned B_SGEI = 12;
  localparam int unsigned B_LCOF = 13;

  typedef logic [CODE_W-1:0] code_t;

  // rank 0 is the highest priority
  function automatic int unsigned prio_bit(int unsigned rank);
    case (rank)
      0:       return B_SEI;
      1:       return B_SSI;
      2:       return B_STI;
      3:       return B_SGEI;
      4:       return B_VSEI;
      5:       return B_VSSI;
      6:       return B_VSTI;
      default: return B_LCOF;
    endcase
  endfunction

  function automatic bit is_sup_bit(int unsigned b);
    return (b == B_SEI) || (b == B_SSI) || (b == B_STI) || (b == B_LCOF);
  endfunction
endpackage

// File: rtl/hv_inj_reg.sv
module hv_inj_reg #(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inj_we,
  input  logic [XLEN-1:0] inj_wdata,
  input  logic            alias_we,
  input  logic [XLEN-1:0] alias_wdata,
  output logic [XLEN-1:0] inj_q
);
  import hv_irq_pkg::*;

  localparam logic [XLEN-1:0] ONE      = XLEN'(1);
  localparam logic [XLEN-1:0] INJ_MASK = (ONE << B_VSEI) | (ONE << B_VSTI) | (ONE << B_VSSI);
  localparam logic [XLEN-1:0] ALI_MASK = ONE << B_VSSI;

  logic vsei_q, vsti_q, vssi_q;

  // the alias write is placed last so it wins bit 2 on a same-cycle collision
  always_ff @(posedge clk) begin
    if (rst) begin
      vsei_q <= 1'b0;
      vsti_q <= 1'b0;
      vssi_q <= 1'b0;
    end else begin
      if (inj_we) begin
        vsei_q <= inj_wdata[B_VSEI];
        vsti_q <= inj_wdata[B_VSTI];
        vssi_q <= inj_wdata[B_VSSI];
      end
      if (alias_we) begin
        vssi_q <= alias_wdata[B_VSSI];
      end
    end
  end

  always_comb begin
    inj_q         = '0;
    inj_q[B_VSEI] = vsei_q;
    inj_q[B_VSTI] = vsti_q;
    inj_q[B_VSSI] = vssi_q;
  end

  logic unused_wr;
  assign unused_wr = ^{inj_wdata & ~INJ_MASK, alias_wdata & ~ALI_MASK};
endmodule

// File: rtl/hv_gst_ext.sv
module hv_gst_ext #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned GEILEN = 6,
  localparam int unsigned SELW  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] gst_pend,
  input  logic [XLEN-1:0] gst_en,
  input  logic [SELW-1:0] gst_sel,
  output logic            sgei,
  output logic            pass
);
  logic [XLEN-1:0] vmask;
  logic            sel_ok;

  // only lines 1..GEILEN exist
  for (genvar gi = 0; gi < XLEN; gi++) begin : g_mask
    if (gi >= 1 && gi <= GEILEN) begin : g_on
      assign vmask[gi] = 1'b1;
    end else begin : g_off
      assign vmask[gi] = 1'b0;
    end
  end

  assign sgei   = |(gst_pend & gst_en & vmask);
  assign sel_ok = (gst_sel != '0) && (int'(gst_sel) <= int'(GEILEN));
  assign pass   = sel_ok & gst_pend[gst_sel];
endmodule

// File: rtl/hv_irq_pick.sv
module hv_irq_pick #(
  parameter int unsigned N = hv_irq_pkg::N_PRIO
) (
  input  logic [N-1:0]       req,
  output logic               valid,
  output hv_irq_pkg::code_t  code
);
  import hv_irq_pkg::*;

  always_comb begin
    valid = 1'b0;
    code  = '0;
    for (int k = int'(N) - 1; k >= 0; k--) begin
      if (req[k]) begin
        valid = 1'b1;
        code  = code_t'(prio_bit(unsigned'(k)));
      end
    end
  end
endmodule

// File: rtl/hv_irq_aggregator.sv
module hv_irq_aggregator #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned GEILEN = 6,
  localparam int unsigned SELW  = $clog2(XLEN)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      inj_we_i,
  input  logic [XLEN-1:0]           inj_wdata_i,
  input  logic                      alias_we_i,
  input  logic [XLEN-1:0]           alias_wdata_i,
  input  logic [XLEN-1:0]           gst_pend_i,
  input  logic [XLEN-1:0]           gst_en_i,
  input  logic [SELW-1:0]           gst_sel_i,
  input  logic                      plat_vsext_i,
  input  logic                      vtimer_hit_i,
  input  logic [XLEN-1:0]           sup_pend_i,
  input  logic [XLEN-1:0]           sup_en_i,
  input  logic [XLEN-1:0]           hyp_en_i,
  output logic [XLEN-1:0]           inj_rd_o,
  output logic [XLEN-1:0]           hyp_pend_o,
  output logic                      sgei_flag_o,
  output logic                      irq_valid_o,
  output logic [hv_irq_pkg::CODE_W-1:0] irq_code_o
);
  import hv_irq_pkg::*;

  localparam logic [XLEN-1:0] ONE      = XLEN'(1);
  localparam logic [XLEN-1:0] SUP_MASK = (ONE << B_SEI) | (ONE << B_SSI) | (ONE << B_STI) | (ONE << B_LCOF);
  localparam logic [XLEN-1:0] HYP_MASK = (ONE << B_SGEI) | (ONE << B_VSEI) | (ONE << B_VSTI) | (ONE << B_VSSI);

  logic [XLEN-1:0]   inj_q;
  logic              sgei_d, pass_d;
  logic [XLEN-1:0]   hyp_next;
  logic [N_PRIO-1:0] rank_req;
  logic              valid_d;
  code_t             code_d;

  hv_inj_reg #(.XLEN(XLEN)) u_inj (
    .clk         (clk),
    .rst         (rst),
    .inj_we      (inj_we_i),
    .inj_wdata   (inj_wdata_i),
    .alias_we    (alias_we_i),
    .alias_wdata (alias_wdata_i),
    .inj_q       (inj_q)
  );

  hv_gst_ext #(.XLEN(XLEN), .GEILEN(GEILEN)) u_gst (
    .gst_pend (gst_pend_i),
    .gst_en   (gst_en_i),
    .gst_sel  (gst_sel_i),
    .sgei     (sgei_d),
    .pass     (pass_d)
  );

  always_comb begin
    hyp_next         = '0;
    hyp_next[B_SGEI] = sgei_d;
    hyp_next[B_VSEI] = inj_q[B_VSEI] | pass_d | plat_vsext_i;
    hyp_next[B_VSTI] = inj_q[B_VSTI] | vtimer_hit_i;
    hyp_next[B_VSSI] = inj_q[B_VSSI];
  end

  // gather pending-and-enabled per rank; supervisor and hypervisor sets stay disjoint
  for (genvar k = 0; k < N_PRIO; k++) begin : g_rank
    localparam int unsigned BITP = prio_bit(k);
    if (is_sup_bit(BITP)) begin : g_sup
      assign rank_req[k] = sup_pend_i[BITP] & sup_en_i[BITP];
    end else begin : g_hyp
      assign rank_req[k] = hyp_next[BITP] & hyp_en_i[BITP];
    end
  end

  hv_irq_pick #(.N(N_PRIO)) u_pick (
    .req   (rank_req),
    .valid (valid_d),
    .code  (code_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hyp_pend_o  <= '0;
      sgei_flag_o <= 1'b0;
      irq_valid_o <= 1'b0;
      irq_code_o  <= '0;
    end else begin
      hyp_pend_o  <= hyp_next;
      sgei_flag_o <= sgei_d;
      irq_valid_o <= valid_d;
      irq_code_o  <= code_d;
    end
  end

  assign inj_rd_o = inj_q;

  logic unused_in;
  assign unused_in = ^{sup_pend_i & ~SUP_MASK, sup_en_i & ~SUP_MASK, hyp_en_i & ~HYP_MASK};
endmodule

// File: rtl/hv_irq_chk.sv
module hv_irq_chk #(
  parameter int unsigned XLEN  = 64,
  localparam int unsigned SELW = $clog2(XLEN)
) (
  input logic                          clk,
  input logic                          rst,
  input logic [XLEN-1:0]               sup_pend_i,
  input logic [XLEN-1:0]               sup_en_i,
  input logic                          plat_vsext_i,
  input logic                          vtimer_hit_i,
  input logic [XLEN-1:0]               inj_rd_o,
  input logic [XLEN-1:0]               hyp_pend_o,
  input logic                          sgei_flag_o,
  input logic                          irq_valid_o,
  input logic [hv_irq_pkg::CODE_W-1:0] irq_code_o
);
  import hv_irq_pkg::*;

  localparam logic [XLEN-1:0] ONE      = XLEN'(1);
  localparam logic [XLEN-1:0] INJ_MASK = (ONE << B_VSEI) | (ONE << B_VSTI) | (ONE << B_VSSI);
  localparam logic [XLEN-1:0] HYP_MASK = INJ_MASK | (ONE << B_SGEI);

  AST_INJ_ONLY_THREE: assert property (@(posedge clk) disable iff (rst)
    (inj_rd_o & ~INJ_MASK) == '0); // R2

  AST_SGEI_MIRROR: assert property (@(posedge clk) disable iff (rst)
    hyp_pend_o[B_SGEI] == sgei_flag_o); // R4

  AST_VSEI_SOURCES: assert property (@(posedge clk) disable iff (rst)
    (plat_vsext_i || inj_rd_o[B_VSEI]) |=> hyp_pend_o[B_VSEI]); // R5

  AST_VSTI_OR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> hyp_pend_o[B_VSTI] == ($past(inj_rd_o[B_VSTI]) | $past(vtimer_hit_i))); // R6

  AST_VSSI_ALIAS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> hyp_pend_o[B_VSSI] == $past(inj_rd_o[B_VSSI])); // R7

  AST_PEND_DISJOINT: assert property (@(posedge clk) disable iff (rst)
    (hyp_pend_o & ~HYP_MASK) == '0); // R8

  AST_SEI_FIRST: assert property (@(posedge clk) disable iff (rst)
    (sup_pend_i[B_SEI] && sup_en_i[B_SEI]) |=> (irq_valid_o && irq_code_o == CODE_W'(B_SEI))); // R9

  AST_IDLE_CODE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !irq_valid_o |-> irq_code_o == '0); // R10
endmodule

bind hv_irq_aggregator hv_irq_chk #(.XLEN(XLEN)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sup_pend_i   (sup_pend_i),
  .sup_en_i     (sup_en_i),
  .plat_vsext_i (plat_vsext_i),
  .vtimer_hit_i (vtimer_hit_i),
  .inj_rd_o     (inj_rd_o),
  .hyp_pend_o   (hyp_pend_o),
  .sgei_flag_o  (sgei_flag_o),
  .irq_valid_o  (irq_valid_o),
  .irq_code_o   (irq_code_o)
);

// File: tb/test_hv_irq_aggregator.sv
module test_hv_irq_aggregator;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN       = 64;
  localparam int GEILEN     = 6;
  localparam int SELW       = $clog2(XLEN);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            inj_we = 1'b0, alias_we = 1'b0;
  logic [XLEN-1:0] inj_wdata = '0, alias_wdata = '0;
  logic [XLEN-1:0] gst_pend = '0, gst_en = '0;
  logic [SELW-1:0] gst_sel = '0;
  logic            plat = 1'b0, vtim = 1'b0;
  logic [XLEN-1:0] sup_pend = '0, sup_en = '0, hyp_en = '0;

  logic [XLEN-1:0] inj_rd, hyp_pend, inj_rd0, hyp_pend0;
  logic            sgei, valid, sgei0, valid0;
  logic [5:0]      code, code0;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hv_irq_aggregator #(.XLEN(XLEN), .GEILEN(GEILEN)) i_hv_irq_aggregator (
    .clk(clk), .rst(rst), .inj_we_i(inj_we), .inj_wdata_i(inj_wdata),
    .alias_we_i(alias_we), .alias_wdata_i(alias_wdata), .gst_pend_i(gst_pend),
    .gst_en_i(gst_en), .gst_sel_i(gst_sel), .plat_vsext_i(plat), .vtimer_hit_i(vtim),
    .sup_pend_i(sup_pend), .sup_en_i(sup_en), .hyp_en_i(hyp_en), .inj_rd_o(inj_rd),
    .hyp_pend_o(hyp_pend), .sgei_flag_o(sgei), .irq_valid_o(valid), .irq_code_o(code));

  // same stimulus, no guest external lines
  hv_irq_aggregator #(.XLEN(XLEN), .GEILEN(0)) i_hv_irq_aggregator_g0 (
    .clk(clk), .rst(rst), .inj_we_i(inj_we), .inj_wdata_i(inj_wdata),
    .alias_we_i(alias_we), .alias_wdata_i(alias_wdata), .gst_pend_i(gst_pend),
    .gst_en_i(gst_en), .gst_sel_i(gst_sel), .plat_vsext_i(plat), .vtimer_hit_i(vtim),
    .sup_pend_i(sup_pend), .sup_en_i(sup_en), .hyp_en_i(hyp_en), .inj_rd_o(inj_rd0),
    .hyp_pend_o(hyp_pend0), .sgei_flag_o(sgei0), .irq_valid_o(valid0), .irq_code_o(code0));

  typedef struct packed {
    logic [15:0] gp;
    logic [15:0] ge;
    logic [5:0]  sel;
    logic        pl;
    logic        vt;
    logic [15:0] sp;
    logic [15:0] se;
    logic [15:0] he;
    logic        ev;
    logic [5:0]  ec;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VT [NV] = '{
    '{16'h0000, 16'h0000, 6'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b0, 6'd0},
    '{16'h0000, 16'h0000, 6'd0, 1'b0, 1'b0, 16'h2000, 16'h2000, 16'h0000, 1'b1, 6'd13},
    '{16'h0000, 16'h0000, 6'd0, 1'b1, 1'b0, 16'h2000, 16'h2000, 16'h0400, 1'b1, 6'd10},
    '{16'h0008, 16'h0008, 6'd3, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h1400, 1'b1, 6'd12},
    '{16'h0001, 16'h0001, 6'd0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'hFFFF, 1'b0, 6'd0},
    '{16'h0080, 16'h0080, 6'd7, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'hFFFF, 1'b0, 6'd0},
    '{16'h0040, 16'h0000, 6'd6, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'hFFFF, 1'b1, 6'd10},
    '{16'h0000, 16'h0000, 6'd0, 1'b0, 1'b1, 16'h0020, 16'h0020, 16'hFFFF, 1'b1, 6'd5},
    '{16'h0000, 16'h0000, 6'd0, 1'b0, 1'b0, 16'h1444, 16'hFFFF, 16'hFFFF, 1'b0, 6'd0},
    '{16'h0000, 16'h0000, 6'd0, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b1, 6'd9},
    '{16'h0000, 16'h0000, 6'd0, 1'b0, 1'b0, 16'h0022, 16'hFFFF, 16'h0000, 1'b1, 6'd1},
    '{16'h0000, 16'h0000, 6'd0, 1'b0, 1'b1, 16'h2000, 16'h2000, 16'h0040, 1'b1, 6'd6},
    '{16'h0000, 16'h0000, 6'd0, 1'b1, 1'b0, 16'h0000, 16'h0000, 16'h0040, 1'b0, 6'd0}
  };

  // expected hypervisor pending value from the requirements
  function automatic logic [XLEN-1:0] model_pend(input logic [XLEN-1:0] inj,
      input logic [XLEN-1:0] gp, input logic [XLEN-1:0] ge, input int sel,
      input logic pl, input logic vt, input int gl);
    logic [XLEN-1:0] vm = '0;
    logic [XLEN-1:0] r = '0;
    logic ps;
    for (int i = 1; i <= gl; i++) vm[i] = 1'b1;
    ps = (sel >= 1 && sel <= gl) ? gp[sel] : 1'b0;
    r[12] = |(gp & ge & vm);
    r[10] = inj[10] | ps | pl;
    r[6]  = inj[6] | vt;
    r[2]  = inj[2];
    return r;
  endfunction

  task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic ie, input logic [XLEN-1:0] idat,
                    input logic ae, input logic [XLEN-1:0] adat);
    inj_we = ie; inj_wdata = idat; alias_we = ae; alias_wdata = adat;
    @(posedge clk);
    @(negedge clk);
    inj_we = 1'b0; alias_we = 1'b0;
  endtask

  task automatic check_zero(input string req);
    chk(req, inj_rd, '0);
    chk(req, hyp_pend, '0);
    chk(req, {63'b0, sgei}, '0);
    chk(req, {63'b0, valid}, '0);
    chk(req, {58'b0, code}, '0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [XLEN-1:0] ep;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_zero("R1 initial reset");
    rst = 1'b0;

    // table phase, injection register stays zero
    for (int v = 0; v < NV; v++) begin
      gst_pend = 64'(VT[v].gp); gst_en = 64'(VT[v].ge); gst_sel = VT[v].sel;
      plat = VT[v].pl; vtim = VT[v].vt;
      sup_pend = 64'(VT[v].sp); sup_en = 64'(VT[v].se); hyp_en = 64'(VT[v].he);
      settle();
      ep = model_pend('0, gst_pend, gst_en, int'(gst_sel), plat, vtim, GEILEN);
      chk("R5 R6 R8 pending", hyp_pend, ep);
      chk("R4 sgei flag", {63'b0, sgei}, {63'b0, ep[12]});
      chk("R9 R10 valid", {63'b0, valid}, {63'b0, VT[v].ev});
      chk("R9 R10 code", {58'b0, code}, {58'b0, VT[v].ec});
      ep = model_pend('0, gst_pend, gst_en, int'(gst_sel), plat, vtim, 0);
      chk("R4 R5 GEILEN0 pending", hyp_pend0, ep);
    end

    // directed: injection register and latency
    gst_pend = '0; gst_en = '0; gst_sel = '0; plat = 0; vtim = 0;
    sup_pend = '0; sup_en = '0; hyp_en = '1;
    settle();
    wr(1'b1, '1, 1'b0, '0);
    chk("R2 inj readback", inj_rd, 64'h444);
    chk("R11 pending lags write", hyp_pend, '0);
    @(posedge clk); @(negedge clk);
    chk("R5 R6 R7 injected", hyp_pend, 64'h444);
    chk("R9 VSEI over VSSI", {58'b0, code}, 64'd10);

    wr(1'b1, 64'h44, 1'b0, '0);
    @(posedge clk); @(negedge clk);
    chk("R9 VSSI over VSTI", {58'b0, code}, 64'd2);

    wr(1'b0, '0, 1'b1, '0);
    chk("R3 alias clears bit2 only", inj_rd, 64'h40);

    wr(1'b1, 64'h400, 1'b1, 64'h4);
    chk("R3 same-cycle writes", inj_rd, 64'h404);

    wr(1'b0, '0, 1'b1, ~64'h4);
    chk("R3 alias ignores other bits", inj_rd, 64'h400);
    @(posedge clk); @(negedge clk);
    chk("R7 VSSI follows alias", hyp_pend, 64'h400);

    // reset after activity
    sup_pend = '1; sup_en = '1;
    settle();
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check_zero("R1 reset after activity");
    rst = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule